// File: doc/BRIEF.md
# Protection FET Gate-Drive Controller

This block holds the digital decisions behind the discharge and charge FET gate drivers of a battery protector. Each driver has its own set of relevant faults, and a per-driver mask picks which of those faults the driver acts on by itself. On top of the fault decision sit several controls:

- a host command that holds a driver off;
- a host command that forces a driver on, which works only when a configuration bit permits forcing;
- a request that turns a driver on to protect the FET body diode.

A shared PWM generator can chop either driver to limit average current.

The discharge output is a plain two-level drive. The same register state also enables the discharge overcurrent comparators, so they run only while the discharge FET is on. The charge output has three states. When the charge driver turns off, it pulls down actively for a fixed number of cycles and then releases the gate. The charge driver may chop only when no charger is present. While a charger is attached, any chopping request keeps the charge driver off.

Top module: `fetdrv_ctrl`

## Requirements
- R1: After reset the discharge drive is low, the comparator enable is low and the charge state is 2'b00 (released).
- R2: The discharge drive goes low one cycle after any masked, active fault in its set. The fault bits are: bit0 cell undervoltage, bit2 discharge over-temperature, bit3 discharge under-temperature, bit6 discharge overcurrent tier 1, bit7 discharge overcurrent tier 2, bit9 short circuit, bit10 diagnostic.
- R3: The charge driver leaves the drive-high state one cycle after any masked, active fault in its set. The fault bits are: bit1 cell overvoltage, bit4 charge over-temperature, bit5 charge under-temperature, bit8 charge overcurrent, bit9 short circuit, bit10 diagnostic.
- R4: A driver ignores a fault whose bit is clear in that driver's mask, and it ignores any fault that is outside its own set.
- R5: A host block command turns the driver off one cycle later.
- R6: A force-on command turns a driver on only while force_allow_i is 1. While force_allow_i is 0 the command has no effect.
- R7: A body-diode request drives the driver on even while a fault trips it.
- R8: The comparator enable equals the discharge drive in every cycle.
- R9: When the charge driver turns off, it enters active pulldown (2'b01) for exactly PULL_CYC cycles and then goes to released (2'b00). The comparator enable does not change during this sequence.
- R10: A charge turn-on during pulldown returns the state to drive high (2'b10) on the next cycle.
- R11: With PWM enabled, a permitted driver is on for min(duty, period+1) cycles of every period+1 cycles.
- R12: While a charger is present and charge PWM is enabled, the charge state never reaches drive high.
- R13: The charge state never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 11 | Active fault flags, bit positions as in R2/R3 |
| dsg_mask_i | input | 11 | Autonomous-control mask for discharge |
| chg_mask_i | input | 11 | Autonomous-control mask for charge |
| dsg_block_i | input | 1 | Host command holding discharge off |
| chg_block_i | input | 1 | Host command holding charge off |
| dsg_force_i | input | 1 | Host force-on for discharge |
| chg_force_i | input | 1 | Host force-on for charge |
| force_allow_i | input | 1 | Configuration bit permitting force-on |
| bdp_dsg_i | input | 1 | Body-diode request for discharge |
| bdp_chg_i | input | 1 | Body-diode request for charge |
| charger_present_i | input | 1 | Charger detected |
| dsg_pwm_en_i | input | 1 | Chop discharge with PWM |
| chg_pwm_en_i | input | 1 | Chop charge with PWM |
| pwm_period_i | input | 8 | PWM period minus one |
| pwm_duty_i | input | 8 | PWM on-count per period |
| dsg_drive_o | output | 1 | Discharge gate drive level |
| chg_state_o | output | 2 | Charge drive state: 00 released, 01 pulldown, 10 high |
| ocd_en_o | output | 1 | Discharge overcurrent comparator enable |

## Verification
Each output is registered once from the inputs, so a change in faults, commands or masks shows up on the first rising edge after it is applied. The pulldown-to-release step lands PULL_CYC edges after the charge state first reads 2'b01. The bench drives inputs on the falling edge and samples one time unit after a rising edge, then counts edges to the exact cycle where each result is due. PWM results do not depend on the counter phase, because the checks count on-cycles over a whole number of periods.

// File: rtl/fetdrv_pkg.sv
package fetdrv_pkg;
  localparam int FLT_W = 11;
  // fault bit positions
  localparam int F_UV = 0, F_OV = 1, F_OTD = 2, F_UTD = 3, F_OTC = 4, F_UTC = 5;
  localparam int F_OCD1 = 6, F_OCD2 = 7, F_OCC = 8, F_SCD = 9, F_DIAG = 10;
  localparam logic [FLT_W-1:0] DSG_SET = (11'd1 << F_UV) | (11'd1 << F_OTD) |
    (11'd1 << F_UTD) | (11'd1 << F_OCD1) | (11'd1 << F_OCD2) |
    (11'd1 << F_SCD) | (11'd1 << F_DIAG);
  localparam logic [FLT_W-1:0] CHG_SET = (11'd1 << F_OV) | (11'd1 << F_OTC) |
    (11'd1 << F_UTC) | (11'd1 << F_OCC) | (11'd1 << F_SCD) | (11'd1 << F_DIAG);

  typedef enum logic [1:0] {
    CHG_REL  = 2'b00,
    CHG_PULL = 2'b01,
    CHG_HIGH = 2'b10
  } chg_state_e;

  function automatic logic pwm_level(input logic [7:0] cnt, input logic [7:0] duty);
    return cnt < duty;
  endfunction

  function automatic logic fault_trip(input logic [FLT_W-1:0] flt,
                                      input logic [FLT_W-1:0] mask,
                                      input logic [FLT_W-1:0] relevant);
    return |(flt & mask & relevant);
  endfunction
endpackage

// File: rtl/fetdrv_pwm.sv
module fetdrv_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PWM_W-1:0] period,
  input  logic [PWM_W-1:0] duty,
  output logic             level
);
  logic [PWM_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q >= period) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign level = cnt_q < duty;
endmodule

// File: rtl/fetdrv_permit.sv
module fetdrv_permit
  import fetdrv_pkg::*;
#(
  parameter logic [FLT_W-1:0] RELEVANT = '0
) (
  input  logic [FLT_W-1:0] fault,
  input  logic [FLT_W-1:0] mask,
  input  logic             block,
  input  logic             force_on,
  input  logic             force_allow,
  input  logic             bdp,
  output logic             trip,
  output logic             permit
);
  always_comb begin
    trip   = fault_trip(fault, mask, RELEVANT);
    permit = bdp || (force_on && force_allow) || (!block && !trip);
  end
endmodule

// File: rtl/fetdrv_chg_seq.sv
module fetdrv_chg_seq
  import fetdrv_pkg::*;
#(
  parameter int PULL_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want_on,
  output chg_state_e state,
  output logic       pd_done
);
  localparam int CW = $clog2(PULL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PULL_CYC - 1);
  logic [CW-1:0] cnt_q;

  assign pd_done = (state == CHG_PULL) && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CHG_REL;
      cnt_q <= '0;
    end else if (want_on) begin
      state <= CHG_HIGH;
      cnt_q <= '0;
    end else begin
      case (state)
        CHG_HIGH: begin
          state <= CHG_PULL;
          cnt_q <= '0;
        end
        CHG_PULL: begin
          if (pd_done) state <= CHG_REL;
          else         cnt_q <= cnt_q + 1'b1;
        end
        default: state <= CHG_REL;
      endcase
    end
  end
endmodule

// File: rtl/fetdrv_ctrl.sv
module fetdrv_ctrl
  import fetdrv_pkg::*;
#(
  parameter int PWM_W    = 8,
  parameter int PULL_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [10:0]      fault_i,
  input  logic [10:0]      dsg_mask_i,
  input  logic [10:0]      chg_mask_i,
  input  logic             dsg_block_i,
  input  logic             chg_block_i,
  input  logic             dsg_force_i,
  input  logic             chg_force_i,
  input  logic             force_allow_i,
  input  logic             bdp_dsg_i,
  input  logic             bdp_chg_i,
  input  logic             charger_present_i,
  input  logic             dsg_pwm_en_i,
  input  logic             chg_pwm_en_i,
  input  logic [PWM_W-1:0] pwm_period_i,
  input  logic [PWM_W-1:0] pwm_duty_i,
  output logic             dsg_drive_o,
  output logic [1:0]       chg_state_o,
  output logic             ocd_en_o
);
  // named internal events for the checker
  logic dsg_trip, chg_trip, dsg_permit, chg_permit;
  logic pwm_lvl, dsg_want, chg_want, chg_pwm_block, pd_done;
  chg_state_e chg_state;

  fetdrv_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .period(pwm_period_i), .duty(pwm_duty_i),
    .level(pwm_lvl)
  );

  fetdrv_permit #(.RELEVANT(DSG_SET)) u_dsg_perm (
    .fault(fault_i), .mask(dsg_mask_i), .block(dsg_block_i),
    .force_on(dsg_force_i), .force_allow(force_allow_i), .bdp(bdp_dsg_i),
    .trip(dsg_trip), .permit(dsg_permit)
  );

  fetdrv_permit #(.RELEVANT(CHG_SET)) u_chg_perm (
    .fault(fault_i), .mask(chg_mask_i), .block(chg_block_i),
    .force_on(chg_force_i), .force_allow(force_allow_i), .bdp(bdp_chg_i),
    .trip(chg_trip), .permit(chg_permit)
  );

  assign chg_pwm_block = chg_pwm_en_i && charger_present_i;
  assign dsg_want = dsg_permit && (!dsg_pwm_en_i || pwm_lvl);
  assign chg_want = chg_permit && !chg_pwm_block && (!chg_pwm_en_i || pwm_lvl);

  logic dsg_q, ocd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsg_q <= 1'b0;
      ocd_q <= 1'b0;
    end else begin
      dsg_q <= dsg_want;
      ocd_q <= dsg_want;
    end
  end

  fetdrv_chg_seq #(.PULL_CYC(PULL_CYC)) u_chg (
    .clk(clk), .rst_n(rst_n), .want_on(chg_want), .state(chg_state),
    .pd_done(pd_done)
  );

  assign dsg_drive_o = dsg_q;
  assign ocd_en_o    = ocd_q;
  assign chg_state_o = chg_state;
endmodule

// File: rtl/fetdrv_ctrl_chk.sv
module fetdrv_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dsg_permit,
  input logic       chg_permit,
  input logic       chg_pwm_block,
  input logic       pd_done,
  input logic       dsg_drive_o,
  input logic       ocd_en_o,
  input logic [1:0] chg_state_o
);
  assert_dsg_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dsg_permit |=> !dsg_drive_o);

  assert_chg_not_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_permit |=> chg_state_o != 2'b10);

  assert_ocd_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ocd_en_o == dsg_drive_o);

  assert_high_to_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_state_o == 2'b10) |=> (chg_state_o == 2'b10 || chg_state_o == 2'b01));

  assert_release_after_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_state_o == 2'b01 && !pd_done) |=> chg_state_o != 2'b00);

  assert_charger_blocks_pwm_R12: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pwm_block |=> chg_state_o != 2'b10);

  assert_state_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
    chg_state_o != 2'b11);
endmodule

bind fetdrv_ctrl fetdrv_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dsg_permit(dsg_permit), .chg_permit(chg_permit),
  .chg_pwm_block(chg_pwm_block), .pd_done(pd_done), .dsg_drive_o(dsg_drive_o),
  .ocd_en_o(ocd_en_o), .chg_state_o(chg_state_o)
);

// File: tb/sim_fetdrv_ctrl.sv
module sim_fetdrv_ctrl;
  localparam int CLK_P = 10;
  localparam int PULL_N = 100;

  logic clk = 0, rst_n = 0;
  logic [10:0] fault_i = '0, dsg_mask_i = '1, chg_mask_i = '1;
  logic dsg_block_i = 0, chg_block_i = 0, dsg_force_i = 0, chg_force_i = 0;
  logic force_allow_i = 0, bdp_dsg_i = 0, bdp_chg_i = 0, charger_present_i = 0;
  logic dsg_pwm_en_i = 0, chg_pwm_en_i = 0;
  logic [7:0] pwm_period_i = 8'd3, pwm_duty_i = 8'd2;
  logic dsg_drive_o, ocd_en_o;
  logic [1:0] chg_state_o;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  fetdrv_ctrl #(.PULL_CYC(PULL_N)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply at falling edge, sample just after next rising edge
  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    fault_i = '0; dsg_mask_i = '1; chg_mask_i = '1;
    dsg_block_i = 0; chg_block_i = 0; dsg_force_i = 0; chg_force_i = 0;
    force_allow_i = 0; bdp_dsg_i = 0; bdp_chg_i = 0; charger_present_i = 0;
    dsg_pwm_en_i = 0; chg_pwm_en_i = 0;
    step(2);
  endtask

  task automatic t_reset();
    chk("R1 dsg", dsg_drive_o, 0);
    chk("R1 ocd", ocd_en_o, 0);
    chk("R1 chg", chg_state_o, 0);
  endtask

  task automatic t_faults();
    settle();
    chk("R2 dsg on idle", dsg_drive_o, 1);
    chk("R3 chg high idle", chg_state_o, 2);
    @(negedge clk); fault_i = 11'h001; step();
    chk("R2 undervolt trips dsg", dsg_drive_o, 0);
    chk("R8 ocd off with dsg", ocd_en_o, 0);
    chk("R4 undervolt ignored by chg", chg_state_o, 2);
    @(negedge clk); fault_i = 11'h002; step();
    chk("R8 ocd back on", ocd_en_o, 1);
    chk("R3 overvolt trips chg", chg_state_o, 1);
    chk("R4 overvolt ignored by dsg", dsg_drive_o, 1);
    settle();
    @(negedge clk); fault_i = 11'h200; step();
    chk("R2 short trips dsg", dsg_drive_o, 0);
    chk("R3 short trips chg", chg_state_o, 1);
    settle();
    @(negedge clk); fault_i = 11'h401; dsg_mask_i = 11'h000; step(3);
    chk("R4 masked fault ignored", dsg_drive_o, 1);
    chk("R8 ocd with masked fault", ocd_en_o, 1);
  endtask

  task automatic t_block_force();
    settle();
    @(negedge clk); dsg_block_i = 1; dsg_force_i = 1; step();
    chk("R5 block dsg", dsg_drive_o, 0);
    chk("R6 force without allow", dsg_drive_o, 0);
    @(negedge clk); force_allow_i = 1; step();
    chk("R6 force with allow", dsg_drive_o, 1);
    @(negedge clk); chg_block_i = 1; step();
    chk("R5 block chg", chg_state_o, 1);
    @(negedge clk); fault_i = 11'h002; chg_force_i = 1; force_allow_i = 0; step();
    chk("R10 stays pulldown when force disallowed", chg_state_o, 1);
    @(negedge clk); force_allow_i = 1; step();
    chk("R10 force cancels pulldown", chg_state_o, 2);
    settle();
    @(negedge clk); fault_i = 11'h003; bdp_dsg_i = 1; bdp_chg_i = 1; step();
    chk("R7 bdp dsg", dsg_drive_o, 1);
    chk("R7 bdp chg", chg_state_o, 2);
  endtask

  task automatic t_pulldown();
    settle();
    @(negedge clk); chg_block_i = 1; step();
    chk("R9 pulldown entered", chg_state_o, 1);
    step(PULL_N - 1);
    chk("R9 pulldown last cycle", chg_state_o, 1);
    chk("R9 ocd unaffected", ocd_en_o, 1);
    step();
    chk("R9 released", chg_state_o, 0);
    @(negedge clk); chg_block_i = 0; step();
    chk("R10 on from released", chg_state_o, 2);
    @(negedge clk); chg_block_i = 1; step(5);
    @(negedge clk); chg_block_i = 0; step();
    chk("R10 cancel mid pulldown", chg_state_o, 2);
  endtask

  task automatic count_on(input int n, output int dn, output int cn);
    dn = 0; cn = 0;
    for (int i = 0; i < n; i++) begin
      step();
      dn += dsg_drive_o;
      cn += (chg_state_o == 2'b10);
    end
  endtask

  task automatic t_pwm();
    int dn, cn;
    settle();
    @(negedge clk); dsg_pwm_en_i = 1; chg_pwm_en_i = 1;
    pwm_period_i = 8'd3; pwm_duty_i = 8'd2; step();
    count_on(8, dn, cn);
    chk("R11 dsg duty 2/4", dn, 4);
    chk("R11 chg duty 2/4", cn, 4);
    @(negedge clk); pwm_duty_i = 8'd0; step();
    count_on(8, dn, cn);
    chk("R11 duty zero", dn, 0);
    @(negedge clk); pwm_duty_i = 8'd9; step();
    count_on(8, dn, cn);
    chk("R11 duty above period", dn, 8);
    @(negedge clk); pwm_duty_i = 8'd2; pwm_period_i = 8'd4; step(6);
    count_on(10, dn, cn);
    chk("R11 duty 2/5", dn, 4);
    @(negedge clk); charger_present_i = 1; step();
    count_on(10, dn, cn);
    chk("R12 chg suppressed with charger", cn, 0);
    chk("R12 dsg pwm unaffected", dn, 4);
    @(negedge clk); fault_i = 11'h001; pwm_duty_i = 8'd9; step();
    chk("R2 fault overrides pwm", dsg_drive_o, 0);
    chk("R13 code valid", int'(chg_state_o != 2'b11), 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 1);
    t_reset();
    @(negedge clk); rst_n = 1;
    step();
    t_faults();
    t_block_force();
    t_pulldown();
    t_pwm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule